// File: doc/BRIEF.md
# DVFS Level Transition Sequencer

This block moves one processor clock domain between five performance levels. The levels are indexed 0 (fastest, 1000 MHz) to 4 (slowest, 100 MHz), with 800, 400 and 200 MHz in between. A requester holds `req_valid` with a target index until it sees a one-cycle `req_ack`. `req_err` travels with the ack and reports a refused or aborted request. The sequencer then works through a fixed chain of steps. Each step writes one group of clock-control outputs, or issues one supply-voltage request, and then waits for the matching status input before the next step starts.

Supplies are raised before any clock change when the target is faster, and lowered after all clock changes when it is slower. When level 0 is the old or the new level, the main PLL is reprogrammed. During the reprogram the media clocks and the core clock are parked on an alternate PLL. When level 4 is involved, the memory-bus divider is also rewritten. Per-level voltage codes and divider values come from a small table held in the package. Every status wait is guarded by a programmable timeout.

Top module: `dvfs_seq`

## Requirements
- R1: Reset state. After reset the level is 1. Both muxes select the main PLL (0). `bus_div` = 0x14131330, `margin` = 1, `pll_cfg` = 0x80640301, `mem_div` = 3, `gfx_div` = `vid_div` = 0, and no ack or voltage request is active.
- R2: A request for the current level is acknowledged in the cycle after acceptance with `req_err` = 0, and no output changes.
- R3: While `lockout` is high, or when `req_level` is above 4, a request is acknowledged with `req_err` = 1 and no output or level changes.
- R4: Speed-up (new index lower than old). The core supply request completes, then the internal supply request completes, before any clock output changes. Core codes for levels 0..4 are 125,120,105,95,95 and internal codes are 110,110,110,110,100 (units of 10 mV).
- R5: Slow-down. After the last clock change, the internal supply request is made first and the core supply request second, using the R4 codes.
- R6: A PLL reprogram happens only when the old or new level is 0. It begins with three steps, each waiting for its busy inputs to clear: `gfx_div` and `vid_div` are set to 3 (divide by 4), then `media_mux_sel` goes to 1, then `core_mux_sel` goes to 1.
- R7: During the reprogram, `pll_lock_time` is loaded with 0x2CF. `pll_cfg` is written with bit 31 = 1, M in bits 25:16, P = 3 in bits 13:8 and S = 1 in bits 2:0; M is 125 for level 0 and 100 otherwise (0x807D0301 / 0x80640301). The sequencer then waits for `pll_locked`.
- R8: After lock, three steps follow in this order, each waiting on its busy status: `media_mux_sel` returns to 0, the media dividers are restored to the level value 0, and `core_mux_sel` returns to 0.
- R9: `bus_div` is written as a whole word, field i in bits 4i+3:4i. The words for levels 0..4 are 0x14131440, 0x14131330, 0x14131131, 0x14131133, 0x09070077. The next step waits until `bus_div_busy` is all zero. This write happens after any parking and before any PLL write.
- R10: `margin` becomes 3 for levels 3 and 4, and 1 for levels 0..2. It is written with `bus_div`.
- R11: Only when the old or new level is 4, `mem_div` is written after all core and PLL steps: 7 for level 4, 3 otherwise. The sequencer then waits for `mem_div_busy` to clear.
- R12: A status wait that lasts `timeout_limit` cycles aborts the request. The request is acknowledged with `req_err` = 1 and `cur_level` unchanged.
- R13: `req_ack` is a single-cycle pulse. On a successful transition `cur_level` holds the new level when the ack is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Level request pending |
| req_level | input | 3 | Requested level index |
| req_ack | output | 1 | One-cycle request completion |
| req_err | output | 1 | Request refused or aborted, valid with ack |
| cur_level | output | 3 | Current level |
| lockout | input | 1 | Refuse all requests |
| timeout_limit | input | 16 | Maximum cycles of one status wait |
| vcore_req | output | 1 | Core supply change request |
| vcore_code | output | 8 | Core supply code |
| vcore_done | input | 1 | Core supply settled |
| vint_req | output | 1 | Internal supply change request |
| vint_code | output | 8 | Internal supply code |
| vint_done | input | 1 | Internal supply settled |
| core_mux_sel | output | 1 | Core clock source, 1 = alternate PLL |
| core_mux_busy | input | 1 | Core mux switching |
| media_mux_sel | output | 1 | Graphics/video clock source, 1 = alternate PLL |
| media_mux_busy | input | 2 | Graphics/video mux switching |
| gfx_div | output | 4 | Graphics clock divider |
| vid_div | output | 4 | Video clock divider |
| media_div_busy | input | 2 | Graphics/video divider settling |
| bus_div | output | 32 | Eight packed bus divider fields |
| bus_div_busy | input | 8 | Bus divider settling |
| mem_div | output | 4 | Memory-bus divider |
| mem_div_busy | input | 1 | Memory divider settling |
| margin | output | 2 | Memory timing margin field |
| pll_lock_time | output | 16 | Main PLL lock time |
| pll_cfg | output | 32 | Main PLL configuration word |
| pll_locked | input | 1 | Main PLL locked |

## Verification
The bench models each status input as a busy window that opens when the matching output changes. It timestamps every output change, so it can catch steps issued out of order. Examples are a voltage request placed after a clock change on a speed-up, the core mux leaving before the media clocks are parked, or the core returning to the main PLL before the media dividers are restored. A design that ignored a busy input would be caught because consecutive steps would sit closer together than the busy window. The bench also exercises transitions that involve only level 4, only level 0, both, and neither. A wrong condition for the PLL or memory path would then show as a PLL word or memory divider written when it should not be, or missing when it should be. Refused requests, same-level requests and a PLL that never locks are also exercised. A design that got these wrong would touch outputs, move `cur_level`, or hang without an error ack.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;

    localparam int NUM_LVL  = 5;
    localparam int LVL_W    = 3;
    localparam int VC_W     = 8;
    localparam int DIV_W    = 4;
    localparam int BUS_FLD  = 8;
    localparam int BUS_W    = BUS_FLD * DIV_W;

    localparam logic [15:0]      PLL_LOCK_CYC   = 16'h02CF;
    localparam logic [9:0]       PLL_M_TOP      = 10'd125;
    localparam logic [9:0]       PLL_M_OTHER    = 10'd100;
    localparam logic [5:0]       PLL_P          = 6'd3;
    localparam logic [2:0]       PLL_S          = 3'd1;
    localparam logic [DIV_W-1:0] MEDIA_PARK_DIV = 4'd3;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_VUP_CORE,
        ST_VUP_INT,
        ST_PRE_DIV,
        ST_PRE_SRC,
        ST_PRE_CORE,
        ST_BUS,
        ST_PLL,
        ST_POST_SRC,
        ST_POST_DIV,
        ST_POST_CORE,
        ST_MEM,
        ST_VDN_INT,
        ST_VDN_CORE,
        ST_FIN
    } step_t;

    typedef struct packed {
        logic [VC_W-1:0]  vcore;
        logic [VC_W-1:0]  vint;
        logic [BUS_W-1:0] bus_div;
        logic [DIV_W-1:0] gfx_div;
        logic [DIV_W-1:0] vid_div;
        logic [DIV_W-1:0] mem_div;
        logic [1:0]       margin;
        logic [31:0]      pll_word;
    } lvl_cfg_t;

    function automatic logic [31:0] make_pll_word(input logic [9:0] m);
        return {1'b1, 5'd0, m, 2'd0, PLL_P, 5'd0, PLL_S};
    endfunction

    function automatic lvl_cfg_t lvl_cfg(input logic [LVL_W-1:0] l);
        lvl_cfg_t c;
        c.gfx_div  = '0;
        c.vid_div  = '0;
        c.margin   = (l >= 3'd3) ? 2'd3 : 2'd1;
        c.mem_div  = (l == 3'd4) ? 4'd7 : 4'd3;
        c.pll_word = make_pll_word((l == 3'd0) ? PLL_M_TOP : PLL_M_OTHER);
        case (l)
            3'd0:    begin c.vcore = 8'd125; c.vint = 8'd110; c.bus_div = 32'h1413_1440; end
            3'd2:    begin c.vcore = 8'd105; c.vint = 8'd110; c.bus_div = 32'h1413_1131; end
            3'd3:    begin c.vcore = 8'd95;  c.vint = 8'd110; c.bus_div = 32'h1413_1133; end
            3'd4:    begin c.vcore = 8'd95;  c.vint = 8'd100; c.bus_div = 32'h0907_0077; end
            default: begin c.vcore = 8'd120; c.vint = 8'd110; c.bus_div = 32'h1413_1330; end
        endcase
        return c;
    endfunction

    function automatic logic step_enabled(input step_t s, input logic up,
                                          input logic pll, input logic bus);
        case (s)
            ST_VUP_CORE, ST_VUP_INT:                 return up;
            ST_PRE_DIV, ST_PRE_SRC, ST_PRE_CORE,
            ST_PLL, ST_POST_SRC, ST_POST_DIV,
            ST_POST_CORE:                            return pll;
            ST_BUS:                                  return 1'b1;
            ST_MEM:                                  return bus;
            ST_VDN_INT, ST_VDN_CORE:                 return !up;
            default:                                 return 1'b0;
        endcase
    endfunction

    function automatic step_t next_step(input step_t cur, input logic up,
                                        input logic pll, input logic bus);
        step_t r;
        r = ST_FIN;
        for (int i = int'(ST_FIN) - 1; i > 0; i--) begin
            if (i > int'(cur) && step_enabled(step_t'(i), up, pll, bus))
                r = step_t'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/dvfs_level_rom.sv
module dvfs_level_rom
    import dvfs_pkg::*;
(
    input  logic [LVL_W-1:0] lvl,
    output lvl_cfg_t         cfg
);
    assign cfg = lvl_cfg(lvl);
endmodule

// File: rtl/dvfs_route.sv
module dvfs_route
    import dvfs_pkg::*;
(
    input  logic [LVL_W-1:0] cur_lvl,
    input  logic [LVL_W-1:0] new_lvl,
    output logic             bad,
    output logic             same,
    output logic             up,
    output logic             pll_chg,
    output logic             bus_chg
);
    localparam logic [LVL_W-1:0] TOP_LVL = '0;
    localparam logic [LVL_W-1:0] BOT_LVL = LVL_W'(NUM_LVL - 1);

    always_comb begin
        bad     = new_lvl > BOT_LVL;
        same    = new_lvl == cur_lvl;
        up      = new_lvl < cur_lvl;
        pll_chg = (new_lvl == TOP_LVL) || (cur_lvl == TOP_LVL);
        bus_chg = (new_lvl == BOT_LVL) || (cur_lvl == BOT_LVL);
    end
endmodule

// File: rtl/dvfs_wait_timer.sv
module dvfs_wait_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [CW-1:0] limit,
    output logic          expired
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (cnt != '1)
            cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt >= limit);

    AST_TMR_RESTART: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt == '0)); // R12
endmodule

// File: rtl/dvfs_seq.sv
module dvfs_seq
    import dvfs_pkg::*;
#(
    parameter int RESET_LEVEL = 1,
    parameter int TMO_W       = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    input  logic [LVL_W-1:0]        req_level,
    output logic                    req_ack,
    output logic                    req_err,
    output logic [LVL_W-1:0]        cur_level,
    input  logic                    lockout,
    input  logic [TMO_W-1:0]        timeout_limit,
    output logic                    vcore_req,
    output logic [VC_W-1:0]         vcore_code,
    input  logic                    vcore_done,
    output logic                    vint_req,
    output logic [VC_W-1:0]         vint_code,
    input  logic                    vint_done,
    output logic                    core_mux_sel,
    input  logic                    core_mux_busy,
    output logic                    media_mux_sel,
    input  logic [1:0]              media_mux_busy,
    output logic [DIV_W-1:0]        gfx_div,
    output logic [DIV_W-1:0]        vid_div,
    input  logic [1:0]              media_div_busy,
    output logic [BUS_W-1:0]        bus_div,
    input  logic [BUS_FLD-1:0]      bus_div_busy,
    output logic [DIV_W-1:0]        mem_div,
    input  logic                    mem_div_busy,
    output logic [1:0]              margin,
    output logic [15:0]             pll_lock_time,
    output logic [31:0]             pll_cfg,
    input  logic                    pll_locked
);
    localparam lvl_cfg_t RST_CFG = lvl_cfg(LVL_W'(RESET_LEVEL));

    step_t             state;
    logic              issued;
    logic [LVL_W-1:0]  cur_q, tgt_q;
    logic              up_q, pll_q, bus_q;
    logic              rt_bad, rt_same, rt_up, rt_pll, rt_bus;
    logic              wait_ok, tmr_run, tmr_exp;
    lvl_cfg_t          cfg;

    dvfs_route u_route (
        .cur_lvl (cur_q),
        .new_lvl (req_level),
        .bad     (rt_bad),
        .same    (rt_same),
        .up      (rt_up),
        .pll_chg (rt_pll),
        .bus_chg (rt_bus)
    );

    dvfs_level_rom u_rom (
        .lvl (tgt_q),
        .cfg (cfg)
    );

    always_comb begin
        case (state)
            ST_VUP_CORE, ST_VDN_CORE:  wait_ok = vcore_done;
            ST_VUP_INT, ST_VDN_INT:    wait_ok = vint_done;
            ST_PRE_DIV, ST_POST_DIV:   wait_ok = (media_div_busy == '0);
            ST_PRE_SRC, ST_POST_SRC:   wait_ok = (media_mux_busy == '0);
            ST_PRE_CORE, ST_POST_CORE: wait_ok = !core_mux_busy;
            ST_BUS:                    wait_ok = (bus_div_busy == '0);
            ST_PLL:                    wait_ok = pll_locked;
            ST_MEM:                    wait_ok = !mem_div_busy;
            default:                   wait_ok = 1'b1;
        endcase
    end

    assign tmr_run = issued && !wait_ok && (state != ST_IDLE) && (state != ST_FIN);

    dvfs_wait_timer #(.CW(TMO_W)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .run     (tmr_run),
        .limit   (timeout_limit),
        .expired (tmr_exp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= ST_IDLE;
            issued        <= 1'b0;
            cur_q         <= LVL_W'(RESET_LEVEL);
            tgt_q         <= LVL_W'(RESET_LEVEL);
            up_q          <= 1'b0;
            pll_q         <= 1'b0;
            bus_q         <= 1'b0;
            req_ack       <= 1'b0;
            req_err       <= 1'b0;
            vcore_req     <= 1'b0;
            vcore_code    <= RST_CFG.vcore;
            vint_req      <= 1'b0;
            vint_code     <= RST_CFG.vint;
            core_mux_sel  <= 1'b0;
            media_mux_sel <= 1'b0;
            gfx_div       <= RST_CFG.gfx_div;
            vid_div       <= RST_CFG.vid_div;
            bus_div       <= RST_CFG.bus_div;
            mem_div       <= RST_CFG.mem_div;
            margin        <= RST_CFG.margin;
            pll_lock_time <= '0;
            pll_cfg       <= RST_CFG.pll_word;
        end else begin
            req_ack <= 1'b0;
            req_err <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid && !req_ack) begin
                        if (lockout || rt_bad) begin
                            req_ack <= 1'b1;
                            req_err <= 1'b1;
                        end else if (rt_same) begin
                            req_ack <= 1'b1;
                        end else begin
                            tgt_q  <= req_level;
                            up_q   <= rt_up;
                            pll_q  <= rt_pll;
                            bus_q  <= rt_bus;
                            issued <= 1'b0;
                            state  <= next_step(ST_IDLE, rt_up, rt_pll, rt_bus);
                        end
                    end
                end
                ST_FIN: begin
                    req_ack <= 1'b1;
                    cur_q   <= tgt_q;
                    state   <= ST_IDLE;
                end
                default: begin
                    if (!issued) begin
                        issued <= 1'b1;
                        case (state)
                            ST_VUP_CORE, ST_VDN_CORE: begin
                                vcore_req  <= 1'b1;
                                vcore_code <= cfg.vcore;
                            end
                            ST_VUP_INT, ST_VDN_INT: begin
                                vint_req  <= 1'b1;
                                vint_code <= cfg.vint;
                            end
                            ST_PRE_DIV: begin
                                gfx_div <= MEDIA_PARK_DIV;
                                vid_div <= MEDIA_PARK_DIV;
                            end
                            ST_PRE_SRC:   media_mux_sel <= 1'b1;
                            ST_PRE_CORE:  core_mux_sel  <= 1'b1;
                            ST_BUS: begin
                                bus_div <= cfg.bus_div;
                                margin  <= cfg.margin;
                            end
                            ST_PLL: begin
                                pll_lock_time <= PLL_LOCK_CYC;
                                pll_cfg       <= cfg.pll_word;
                            end
                            ST_POST_SRC:  media_mux_sel <= 1'b0;
                            ST_POST_DIV: begin
                                gfx_div <= cfg.gfx_div;
                                vid_div <= cfg.vid_div;
                            end
                            ST_POST_CORE: core_mux_sel <= 1'b0;
                            ST_MEM:       mem_div      <= cfg.mem_div;
                            default: ;
                        endcase
                    end else if (wait_ok) begin
                        issued    <= 1'b0;
                        vcore_req <= 1'b0;
                        vint_req  <= 1'b0;
                        state     <= next_step(state, up_q, pll_q, bus_q);
                    end else if (tmr_exp) begin
                        issued    <= 1'b0;
                        vcore_req <= 1'b0;
                        vint_req  <= 1'b0;
                        req_ack   <= 1'b1;
                        req_err   <= 1'b1;
                        state     <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    assign cur_level = cur_q;

    AST_ACK_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
        req_ack |=> !req_ack); // R13
    AST_LOCKOUT_REFUSED: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && req_valid && !req_ack && lockout) |=> (req_ack && req_err)); // R3
    AST_CORE_PARK_AFTER_MEDIA: assert property (@(posedge clk) disable iff (rst)
        $rose(core_mux_sel) |-> media_mux_sel); // R6
    AST_PLL_WRITE_PARKED: assert property (@(posedge clk) disable iff (rst)
        !$stable(pll_cfg) |-> core_mux_sel); // R7
    AST_CORE_RETURN_LOCKED: assert property (@(posedge clk) disable iff (rst)
        $fell(core_mux_sel) |-> (pll_locked && !media_mux_sel)); // R8
    AST_BUS_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |=> $stable(bus_div)); // R2
endmodule

// File: tb/sim_dvfs_seq.sv
module sim_dvfs_seq;
    localparam int BUSY_CYC = 4;
    localparam int LOCK_CYC = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [2:0]  req_level = 3'd0;
    logic        req_ack, req_err;
    logic [2:0]  cur_level;
    logic        lockout = 1'b0;
    logic [15:0] timeout_limit = 16'd1000;
    logic        vcore_req, vint_req;
    logic [7:0]  vcore_code, vint_code;
    logic        vcore_done = 1'b0, vint_done = 1'b0;
    logic        core_mux_sel, media_mux_sel;
    logic        core_mux_busy = 1'b0;
    logic [1:0]  media_mux_busy = 2'b0, media_div_busy = 2'b0;
    logic [3:0]  gfx_div, vid_div, mem_div;
    logic [31:0] bus_div, pll_cfg;
    logic [7:0]  bus_div_busy = 8'h0;
    logic        mem_div_busy = 1'b0;
    logic [1:0]  margin;
    logic [15:0] pll_lock_time;
    logic        pll_locked = 1'b1;

    always #2 clk = ~clk;

    dvfs_seq u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_level(req_level),
        .req_ack(req_ack), .req_err(req_err), .cur_level(cur_level),
        .lockout(lockout), .timeout_limit(timeout_limit),
        .vcore_req(vcore_req), .vcore_code(vcore_code), .vcore_done(vcore_done),
        .vint_req(vint_req), .vint_code(vint_code), .vint_done(vint_done),
        .core_mux_sel(core_mux_sel), .core_mux_busy(core_mux_busy),
        .media_mux_sel(media_mux_sel), .media_mux_busy(media_mux_busy),
        .gfx_div(gfx_div), .vid_div(vid_div), .media_div_busy(media_div_busy),
        .bus_div(bus_div), .bus_div_busy(bus_div_busy),
        .mem_div(mem_div), .mem_div_busy(mem_div_busy), .margin(margin),
        .pll_lock_time(pll_lock_time), .pll_cfg(pll_cfg), .pll_locked(pll_locked)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0, errors = 0, t_start = 0;
    bit stall_lock = 1'b0;

    int ev_vc = -1, ev_vi = -1, ev_gvtmp = -1, ev_gvrst = -1, ev_gvalt = -1, ev_gvmain = -1;
    int ev_calt = -1, ev_cmain = -1, ev_bus = -1, ev_pll = -1, ev_mem = -1;
    logic [7:0] code_vc = 0, code_vi = 0;
    logic p_vc = 0, p_vi = 0, p_cm = 0, p_mm = 0;
    logic [3:0] p_gfx = 0, p_mem = 3;
    logic [31:0] p_bus = 32'h14131330, p_pll = 32'h80640301;
    int c_vc = 0, c_vi = 0, c_cm = 0, c_mm = 0, c_md = 0, c_bus = 0, c_mem = 0, c_lk = 0;

    // Environment model and event timestamps, evaluated away from the active edge
    always @(negedge clk) begin
        if (vcore_req && !p_vc) begin ev_vc = cyc; code_vc = vcore_code; end
        if (vint_req && !p_vi)  begin ev_vi = cyc; code_vi = vint_code; end
        if (gfx_div != p_gfx) begin
            if (gfx_div == 4'd3) ev_gvtmp = cyc; else ev_gvrst = cyc;
            c_md = BUSY_CYC;
        end
        if (media_mux_sel != p_mm) begin
            if (media_mux_sel) ev_gvalt = cyc; else ev_gvmain = cyc;
            c_mm = BUSY_CYC;
        end
        if (core_mux_sel != p_cm) begin
            if (core_mux_sel) ev_calt = cyc; else ev_cmain = cyc;
            c_cm = BUSY_CYC;
        end
        if (bus_div != p_bus) begin ev_bus = cyc; c_bus = BUSY_CYC; end
        if (mem_div != p_mem) begin ev_mem = cyc; c_mem = BUSY_CYC; end
        if (pll_cfg != p_pll) begin ev_pll = cyc; c_lk = LOCK_CYC; end
        p_vc = vcore_req; p_vi = vint_req; p_gfx = gfx_div; p_mm = media_mux_sel;
        p_cm = core_mux_sel; p_bus = bus_div; p_mem = mem_div; p_pll = pll_cfg;

        media_div_busy = (c_md != 0) ? 2'b11 : 2'b00;
        media_mux_busy = (c_mm != 0) ? 2'b11 : 2'b00;
        core_mux_busy  = (c_cm != 0);
        bus_div_busy   = (c_bus != 0) ? 8'hFF : 8'h00;
        mem_div_busy   = (c_mem != 0);
        pll_locked     = (c_lk == 0) && !stall_lock;
        if (c_md  > 0) c_md--;
        if (c_mm  > 0) c_mm--;
        if (c_cm  > 0) c_cm--;
        if (c_bus > 0) c_bus--;
        if (c_mem > 0) c_mem--;
        if (c_lk  > 0) c_lk--;

        if (!vcore_req) begin vcore_done = 0; c_vc = 0; end
        else if (!vcore_done) begin if (c_vc == 3) vcore_done = 1; else c_vc++; end
        if (!vint_req) begin vint_done = 0; c_vi = 0; end
        else if (!vint_done) begin if (c_vi == 3) vint_done = 1; else c_vi++; end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input longint act, input longint exp);
        chk(act == exp, tag, act, exp);
    endtask

    function automatic bit seen(input int ev);
        return ev >= t_start;
    endfunction

    task automatic chk_before(input string tag, input int a, input int b);
        chk(seen(a) && b > a, tag, a, b);
    endtask

    task automatic do_req(input logic [2:0] lvl, output logic e, output int lat);
        int n;
        @(negedge clk);
        t_start = cyc;
        req_valid = 1'b1;
        req_level = lvl;
        n = 0;
        @(negedge clk);
        while (!req_ack && n < 3000) begin @(negedge clk); n++; end
        lat = n;
        e = req_err;
        chk(req_ack, "R13 ack seen", req_ack, 1);
        req_valid = 1'b0;
        @(negedge clk);
        chk(!req_ack, "R13 ack single pulse", req_ack, 0);
    endtask

    task automatic t_reset;
        chk_eq("R1 level", cur_level, 1);
        chk_eq("R1 core mux", core_mux_sel, 0);
        chk_eq("R1 media mux", media_mux_sel, 0);
        chk_eq("R1 bus_div", bus_div, 32'h14131330);
        chk_eq("R1 margin", margin, 1);
        chk_eq("R1 pll_cfg", pll_cfg, 32'h80640301);
        chk_eq("R1 mem_div", mem_div, 3);
        chk_eq("R1 gfx_div", gfx_div, 0);
        chk_eq("R1 idle outputs", {req_ack, vcore_req, vint_req}, 0);
    endtask

    task automatic t_same;
        logic e; int lat;
        do_req(3'd1, e, lat);
        chk_eq("R2 err", e, 0);
        chk(lat <= 1, "R2 latency", lat, 1);
        chk(!seen(ev_bus) && !seen(ev_vc) && !seen(ev_vi), "R2 no side effect", ev_bus, -1);
        chk_eq("R2 level", cur_level, 1);
    endtask

    task automatic t_refused;
        logic e; int lat;
        lockout = 1'b1;
        do_req(3'd0, e, lat);
        lockout = 1'b0;
        chk_eq("R3 lockout err", e, 1);
        chk(!seen(ev_vc) && !seen(ev_calt) && !seen(ev_bus), "R3 lockout untouched", ev_vc, -1);
        do_req(3'd7, e, lat);
        chk_eq("R3 bad level err", e, 1);
        chk(!seen(ev_vc) && !seen(ev_bus), "R3 bad level untouched", ev_bus, -1);
        chk_eq("R3 level kept", cur_level, 1);
    endtask

    task automatic t_down_plain;
        logic e; int lat;
        do_req(3'd2, e, lat);
        chk_eq("R13 err", e, 0);
        chk_eq("R9 bus_div L2", bus_div, 32'h14131131);
        chk_before("R5 int after bus", ev_bus, ev_vi);
        chk_before("R5 core after int", ev_vi, ev_vc);
        chk_eq("R5 int code", code_vi, 110);
        chk_eq("R5 core code", code_vc, 105);
        chk(!seen(ev_calt) && !seen(ev_pll), "R6 no pll path", ev_pll, -1);
        chk(!seen(ev_mem), "R11 no mem change", ev_mem, -1);
        chk_eq("R10 margin L2", margin, 1);
        chk_eq("R13 level", cur_level, 2);
    endtask

    task automatic t_margin;
        logic e; int lat;
        do_req(3'd3, e, lat);
        chk_eq("R10 margin L3", margin, 3);
        chk_eq("R9 bus_div L3", bus_div, 32'h14131133);
    endtask

    task automatic t_up_pll;
        logic e; int lat;
        do_req(3'd0, e, lat);
        chk_eq("R13 err", e, 0);
        chk_before("R4 core before int", ev_vc, ev_vi);
        chk_before("R4 volts before clocks", ev_vi, ev_gvtmp);
        chk_eq("R4 core code", code_vc, 125);
        chk_eq("R4 int code", code_vi, 110);
        chk_before("R6 media div then src", ev_gvtmp, ev_gvalt);
        chk(ev_gvalt - ev_gvtmp >= BUSY_CYC, "R6 div busy wait", ev_gvalt - ev_gvtmp, BUSY_CYC);
        chk_before("R6 media src then core", ev_gvalt, ev_calt);
        chk_before("R9 bus after park", ev_calt, ev_bus);
        chk_before("R9 pll after bus", ev_bus, ev_pll);
        chk(ev_pll - ev_bus >= BUSY_CYC, "R9 bus busy wait", ev_pll - ev_bus, BUSY_CYC);
        chk_eq("R7 pll word L0", pll_cfg, 32'h807D0301);
        chk_eq("R7 lock time", pll_lock_time, 16'h02CF);
        chk(ev_gvmain - ev_pll >= LOCK_CYC, "R7 lock wait", ev_gvmain - ev_pll, LOCK_CYC);
        chk_before("R8 src then div", ev_gvmain, ev_gvrst);
        chk_before("R8 div then core", ev_gvrst, ev_cmain);
        chk_eq("R8 media div restored", {gfx_div, vid_div}, 0);
        chk_eq("R9 bus_div L0", bus_div, 32'h14131440);
        chk_eq("R10 margin L0", margin, 1);
        chk(!seen(ev_mem), "R11 no mem change", ev_mem, -1);
        chk_eq("R13 level", cur_level, 0);
    endtask

    task automatic t_down_both;
        logic e; int lat;
        do_req(3'd4, e, lat);
        chk_eq("R7 pll word L4", pll_cfg, 32'h80640301);
        chk_before("R11 mem after core return", ev_cmain, ev_mem);
        chk_eq("R11 mem_div L4", mem_div, 7);
        chk_before("R5 int after mem", ev_mem, ev_vi);
        chk_before("R5 core after int", ev_vi, ev_vc);
        chk_eq("R5 codes L4", {code_vc, code_vi}, {8'd95, 8'd100});
        chk_eq("R9 bus_div L4", bus_div, 32'h09070077);
        chk_eq("R10 margin L4", margin, 3);
        chk_eq("R13 level", cur_level, 4);
    endtask

    task automatic t_up_bus;
        logic e; int lat;
        do_req(3'd1, e, lat);
        chk_before("R4 core before int", ev_vc, ev_vi);
        chk_before("R4 int before bus", ev_vi, ev_bus);
        chk_eq("R4 codes L1", {code_vc, code_vi}, {8'd120, 8'd110});
        chk(!seen(ev_pll) && !seen(ev_calt), "R6 no pll when L0 absent", ev_pll, -1);
        chk_before("R11 mem after bus", ev_bus, ev_mem);
        chk(ev_mem - ev_bus >= BUSY_CYC, "R9 bus busy wait", ev_mem - ev_bus, BUSY_CYC);
        chk_eq("R11 mem_div L1", mem_div, 3);
        chk_eq("R9 bus_div L1", bus_div, 32'h14131330);
        chk_eq("R13 level", cur_level, 1);
    endtask

    task automatic t_timeout;
        logic e; int lat;
        stall_lock = 1'b1;
        timeout_limit = 16'd20;
        do_req(3'd0, e, lat);
        chk_eq("R12 abort err", e, 1);
        chk(seen(ev_pll), "R12 reached pll wait", ev_pll, t_start);
        chk(lat < 200, "R12 bounded abort", lat, 200);
        chk_eq("R12 level kept", cur_level, 1);
    endtask

    initial begin
        bit wd = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        fork
            begin
                t_reset;
                t_same;
                t_refused;
                t_down_plain;
                t_margin;
                t_up_pll;
                t_down_both;
                t_up_bus;
                t_timeout;
            end
            begin
                repeat (100000) @(posedge clk);
                wd = 1'b1;
            end
        join_any
        if (wd) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule